// File: doc/BRIEF.md
# Branch-Count Fetch Gating Controller

This block decides, every cycle, whether the front end should stop fetching in order to save the energy that would be spent on instructions past a likely misprediction. It keeps a running count of conditional branches that have been fetched but not yet resolved. Fetch is gated once that count climbs above a threshold. The threshold is not fixed. At the end of every measurement interval it is chosen again from the prediction accuracy seen during that interval. A well-predicted program phase tolerates more unresolved branches before gating.

Execution down a wrong path sometimes pays off, because its loads warm the cache for the correct path. Two vetoes cover this. The first is a small saturating counter of useful wrong-path references. While that counter is above a threshold, gating is held off. The counter is cleared at every interval boundary so that it reflects only the current phase. The second veto is a per-branch hint from an external usefulness predictor. It suppresses gating in the same cycle it is raised.

Top module: `fetch_gate_ctrl`

## Requirements
- R1: After reset, `gateEn` is 0 and `curThresh` equals `INIT_THR` (default 3).
- R2: When neither veto is active, `gateEn` is 1 exactly when the in-flight branch count is strictly greater than `curThresh`. A count equal to the threshold does not gate.
- R3: Each cycle the in-flight count rises by one for `brFetch` and falls by one for `brResolve`. When both are high in the same cycle the count is unchanged. A resolve at a count of zero leaves the count at zero, and the count saturates at its maximum.
- R4: When `flush` is high, the count is loaded from `survivorCnt` at the next edge. This load takes priority over `brFetch` and `brResolve` in the same cycle.
- R5: Every `PERIOD` cycles after reset, the threshold is set from this interval's accuracy A = 1 − mispredicts/resolved. The mapping is: A ≥ 99% gives 18, A ≥ 97% gives 16, A ≥ 95% gives 13, A ≥ 93% gives 12, A ≥ 90% gives 11, A ≥ 85% gives 7, and anything lower gives 3. Each lower bound is inclusive. Between boundaries the threshold does not change.
- R6: An interval with no resolved branch leaves the threshold unchanged.
- R7: Each `usefulPulse` raises a 5-bit usefulness counter by one, saturating at 31. While that counter is greater than `USE_THR`, `gateEn` is 0.
- R8: The usefulness counter is cleared at every interval boundary. A pulse that arrives in the boundary cycle is dropped.
- R9: While `hintUseful` is 1, `gateEn` is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| brFetch | input | 1 | A conditional branch was fetched this cycle |
| brResolve | input | 1 | A conditional branch resolved this cycle |
| brMispred | input | 1 | The resolving branch was mispredicted (qualified by brResolve) |
| flush | input | 1 | Pipeline flush; reload the in-flight count |
| survivorCnt | input | CNT_W | Unresolved branches that survive the flush |
| usefulPulse | input | 1 | One useful wrong-path memory reference was detected |
| hintUseful | input | 1 | Per-branch predictor reports the fetched branch as useful |
| gateEn | output | 1 | Stall fetch this cycle |
| curThresh | output | 5 | Threshold currently in force |

## Verification
The count comparison is driven to one below, exactly at, and one above the threshold. This is done both at the initial threshold of 3 and at the top threshold of 18, which separates a strict comparison from an inclusive one. Stimulus that would underflow the count, fetch and resolve in the same cycle, and flushes combined with fetch and resolve separate saturation, cancellation and load priority from plain up/down counting.

Intervals of 100 resolved branches are run with mispredict counts placed exactly on each accuracy boundary and one step past it, which fixes both the bucket order and the inclusive edge. An interval with no resolves shows that the threshold is held. A burst of 36 usefulness pulses distinguishes saturation from wrap-around.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

  localparam int THR_W      = 5;
  localparam int USE_W      = 5;
  localparam int NUM_BOUNDS = 6;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic periodEnd;
    logic cntLoad;
    logic cntUp;
    logic cntDown;
    logic resolveEv;
    logic mispredEv;
    logic useInc;
  } fgcStrobe_t;

  // Lower accuracy bound (percent) of bucket idx; order is the priority.
  function automatic int unsigned boundPct(input int idx);
    case (idx)
      0:       return 99;
      1:       return 97;
      2:       return 95;
      3:       return 93;
      4:       return 90;
      default: return 85;
    endcase
  endfunction

  // Threshold of bucket idx; idx NUM_BOUNDS is the catch-all bucket.
  function automatic logic [THR_W-1:0] bucketThr(input int idx);
    case (idx)
      0:       return THR_W'(18);
      1:       return THR_W'(16);
      2:       return THR_W'(13);
      3:       return THR_W'(12);
      4:       return THR_W'(11);
      5:       return THR_W'(7);
      default: return THR_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/fgc_ctrl.sv
module fgc_ctrl
  import fgc_pkg::*;
#(
  parameter int PERIOD = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       brFetch,
  input  logic       brResolve,
  input  logic       brMispred,
  input  logic       flush,
  input  logic       usefulPulse,
  output fgcStrobe_t strb
);

  localparam int PER_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [PER_W-1:0] periodCnt;
  logic             lastCycle;

  assign lastCycle = (periodCnt == PER_W'(PERIOD - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          periodCnt <= '0;
    else if (lastCycle) periodCnt <= '0;
    else                periodCnt <= periodCnt + 1'b1;
  end

  always_comb begin
    strb.periodEnd = lastCycle;
    strb.cntLoad   = flush;
    strb.cntUp     = !flush && brFetch && !brResolve;
    strb.cntDown   = !flush && brResolve && !brFetch;
    strb.resolveEv = brResolve;
    strb.mispredEv = brResolve && brMispred;
    strb.useInc    = usefulPulse && !lastCycle;
  end

endmodule

// File: rtl/fgc_datapath.sv
module fgc_datapath
  import fgc_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int PERIOD   = 1024,
  parameter int USE_THR  = 7,
  parameter int INIT_THR = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  fgcStrobe_t       strb,
  input  logic [CNT_W-1:0] survivorCnt,
  input  logic             hintUseful,
  output logic             gateEn,
  output logic [THR_W-1:0] curThresh
);

  localparam int RES_W  = $clog2(PERIOD + 1);
  localparam int PROD_W = RES_W + 7;
  localparam int CMP_W  = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CNT_W-1:0]  inflight;
  logic [RES_W-1:0]  resAcc, misAcc, resNext, misNext;
  logic [PROD_W-1:0] misScaled;
  logic [NUM_BOUNDS-1:0] passB;
  logic [THR_W-1:0]  selThr, thrReg;
  logic [USE_W-1:0]  useCnt;

  // In-flight unresolved branch count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      inflight <= '0;
    else if (strb.cntLoad)
      inflight <= survivorCnt;
    else if (strb.cntUp && (inflight != {CNT_W{1'b1}}))
      inflight <= inflight + 1'b1;
    else if (strb.cntDown && (inflight != '0))
      inflight <= inflight - 1'b1;
  end

  // Per-interval accuracy counters
  assign resNext = resAcc + RES_W'(strb.resolveEv);
  assign misNext = misAcc + RES_W'(strb.mispredEv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resAcc <= '0;
      misAcc <= '0;
    end else if (strb.periodEnd) begin
      resAcc <= '0;
      misAcc <= '0;
    end else begin
      resAcc <= resNext;
      misAcc <= misNext;
    end
  end

  // Divider-free bucket test: mis*100 <= res*(100-bound)
  assign misScaled = PROD_W'(misNext) * PROD_W'(100);

  for (genvar g = 0; g < NUM_BOUNDS; g++) begin : g_bound
    logic [PROD_W-1:0] resScaled;
    assign resScaled = PROD_W'(resNext) * PROD_W'(100 - boundPct(g));
    assign passB[g]  = (misScaled <= resScaled);
  end

  always_comb begin
    selThr = bucketThr(NUM_BOUNDS);
    for (int i = NUM_BOUNDS - 1; i >= 0; i--)
      if (passB[i]) selThr = bucketThr(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      thrReg <= THR_W'(INIT_THR);
    else if (strb.periodEnd && (resNext != '0))
      thrReg <= selThr;
  end

  // Phase usefulness counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      useCnt <= '0;
    else if (strb.periodEnd)
      useCnt <= '0;
    else if (strb.useInc && (useCnt != {USE_W{1'b1}}))
      useCnt <= useCnt + 1'b1;
  end

  logic overThr, phaseVeto;
  assign overThr   = CMP_W'(inflight) > CMP_W'(thrReg);
  assign phaseVeto = useCnt > USE_W'(USE_THR);
  assign gateEn    = overThr && !phaseVeto && !hintUseful;
  assign curThresh = thrReg;

endmodule

// File: rtl/fetch_gate_ctrl.sv
module fetch_gate_ctrl
  import fgc_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int PERIOD   = 1024,
  parameter int USE_THR  = 7,
  parameter int INIT_THR = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brFetch,
  input  logic             brResolve,
  input  logic             brMispred,
  input  logic             flush,
  input  logic [CNT_W-1:0] survivorCnt,
  input  logic             usefulPulse,
  input  logic             hintUseful,
  output logic             gateEn,
  output logic [4:0]       curThresh
);

  fgcStrobe_t strb;

  fgc_ctrl #(.PERIOD(PERIOD)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .brFetch     (brFetch),
    .brResolve   (brResolve),
    .brMispred   (brMispred),
    .flush       (flush),
    .usefulPulse (usefulPulse),
    .strb        (strb)
  );

  fgc_datapath #(
    .CNT_W   (CNT_W),
    .PERIOD  (PERIOD),
    .USE_THR (USE_THR),
    .INIT_THR(INIT_THR)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .survivorCnt (survivorCnt),
    .hintUseful  (hintUseful),
    .gateEn      (gateEn),
    .curThresh   (curThresh)
  );

endmodule

// File: rtl/fgc_checker.sv
module fgc_checker #(
  parameter int CNT_W    = 6,
  parameter int PERIOD   = 1024,
  parameter int INIT_THR = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             brFetch,
  input logic             flush,
  input logic [CNT_W-1:0] survivorCnt,
  input logic             hintUseful,
  input logic             gateEn,
  input logic [4:0]       curThresh
);

  localparam int PER_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [PER_W-1:0] chkCyc;
  logic             boundary;

  assign boundary = (chkCyc == PER_W'(PERIOD - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         chkCyc <= '0;
    else if (boundary) chkCyc <= '0;
    else               chkCyc <= chkCyc + 1'b1;
  end

  // R1
  reset_thr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (curThresh == 5'(INIT_THR)));

  // R9
  hint_veto_chk: assert property (@(posedge clk) disable iff (!rstN)
    hintUseful |-> !gateEn);

  // R4
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flush && (survivorCnt == '0)) |=> !gateEn);

  // R5
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable(curThresh));

  // R5
  thr_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curThresh inside {5'd3, 5'd7, 5'd11, 5'd12, 5'd13, 5'd16, 5'd18, 5'(INIT_THR)}));

  // R3
  no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!gateEn && !hintUseful && !flush && !brFetch && !boundary) |=> !gateEn);

endmodule

bind fetch_gate_ctrl fgc_checker #(
  .CNT_W   (CNT_W),
  .PERIOD  (PERIOD),
  .INIT_THR(INIT_THR)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .brFetch     (brFetch),
  .flush       (flush),
  .survivorCnt (survivorCnt),
  .hintUseful  (hintUseful),
  .gateEn      (gateEn),
  .curThresh   (curThresh)
);

// File: tb/fetch_gate_ctrl_tb.sv
module fetch_gate_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int PERIOD     = 128;
  localparam int USE_THR    = 4;
  localparam int INIT_THR   = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             brFetch = 1'b0, brResolve = 1'b0, brMispred = 1'b0;
  logic             flush = 1'b0, usefulPulse = 1'b0, hintUseful = 1'b0;
  logic [CNT_W-1:0] survivorCnt = '0;
  logic             gateEn;
  logic [4:0]       curThresh;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  fetch_gate_ctrl #(
    .CNT_W(CNT_W), .PERIOD(PERIOD), .USE_THR(USE_THR), .INIT_THR(INIT_THR)
  ) u_dut (
    .clk(clk), .rstN(rstN), .brFetch(brFetch), .brResolve(brResolve),
    .brMispred(brMispred), .flush(flush), .survivorCnt(survivorCnt),
    .usefulPulse(usefulPulse), .hintUseful(hintUseful),
    .gateEn(gateEn), .curThresh(curThresh)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    brFetch = 0; brResolve = 0; brMispred = 0; flush = 0;
    usefulPulse = 0; hintUseful = 0;
  endtask

  task automatic fetchN(input int n);
    for (int i = 0; i < n; i++) begin brFetch = 1; step(); end
    idle();
  endtask

  task automatic resolveN(input int n);
    for (int i = 0; i < n; i++) begin brResolve = 1; step(); end
    idle();
  endtask

  task automatic doFlush(input int surv, input bit withFetch, input bit withRes);
    flush = 1; survivorCnt = CNT_W'(surv); brFetch = withFetch; brResolve = withRes;
    step();
    idle();
  endtask

  task automatic alignPeriod();
    while (cyc % PERIOD != 0) step();
  endtask

  task automatic testReset();
    check("R1 gate", int'(gateEn), 0);
    check("R1 thresh", int'(curThresh), INIT_THR);
  endtask

  task automatic testCounting();
    alignPeriod();
    fetchN(3);
    check("R2 equal count", int'(gateEn), 0);
    fetchN(1);
    check("R2 above", int'(gateEn), 1);
    hintUseful = 1; #1;
    check("R9 hint veto", int'(gateEn), 0);
    hintUseful = 0; #1;
    check("R9 hint release", int'(gateEn), 1);
    brFetch = 1; brResolve = 1; step(); idle();
    check("R3 cancel", int'(gateEn), 1);
    resolveN(1);
    check("R3 decrement", int'(gateEn), 0);
    resolveN(6);
    fetchN(3);
    check("R3 no underflow at 3", int'(gateEn), 0);
    fetchN(1);
    check("R3 no underflow at 4", int'(gateEn), 1);
    doFlush(10, 1, 1);
    resolveN(6);
    check("R4 reload to 10 then -6", int'(gateEn), 1);
    resolveN(1);
    check("R4 reload exact", int'(gateEn), 0);
    doFlush(2, 1, 0);
    fetchN(1);
    check("R4 flush priority", int'(gateEn), 0);
    doFlush(0, 0, 0);
  endtask

  task automatic runPeriod(input int res, input int mis, input int expThr, input string req);
    alignPeriod();
    for (int i = 0; i < res; i++) begin
      brResolve = 1; brMispred = (i < mis); step();
    end
    idle();
    alignPeriod();
    check(req, int'(curThresh), expThr);
  endtask

  task automatic testThresholds();
    runPeriod(100, 0,  18, "R5 100%");
    runPeriod(100, 2,  16, "R5 98%");
    runPeriod(100, 1,  18, "R5 99% inclusive");
    runPeriod(100, 3,  16, "R5 97% inclusive");
    runPeriod(100, 4,  13, "R5 96%");
    runPeriod(100, 5,  13, "R5 95% inclusive");
    runPeriod(100, 7,  12, "R5 93% inclusive");
    runPeriod(100, 10, 11, "R5 90% inclusive");
    runPeriod(0,   0,  11, "R6 empty interval holds");
    runPeriod(100, 15, 7,  "R5 85% inclusive");
    runPeriod(100, 16, 3,  "R5 84%");
  endtask

  task automatic testHighThreshold();
    runPeriod(100, 0, 18, "R5 back to 18");
    doFlush(18, 0, 0);
    check("R2 equal at 18", int'(gateEn), 0);
    fetchN(1);
    check("R2 above 18", int'(gateEn), 1);
    doFlush(0, 0, 0);
  endtask

  task automatic testUsefulness();
    alignPeriod();
    doFlush(30, 0, 0);
    check("R2 gate before pulses", int'(gateEn), 1);
    for (int i = 0; i < USE_THR; i++) begin usefulPulse = 1; step(); end
    idle();
    check("R7 at threshold", int'(gateEn), 1);
    usefulPulse = 1; step(); idle();
    check("R7 above threshold", int'(gateEn), 0);
    alignPeriod();
    check("R8 cleared at boundary", int'(gateEn), 1);
    for (int i = 0; i < 36; i++) begin usefulPulse = 1; step(); end
    idle();
    check("R7 saturates", int'(gateEn), 0);
    doFlush(0, 0, 0);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    step();
    testReset();
    testCounting();
    testThresholds();
    testHighThreshold();
    testUsefulness();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule